// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a real address by searching a hashed page table held in memory. A small file of sixteen segment registers supplies a 24-bit virtual segment ID, chosen by the top four address bits. The walker hashes that ID with the page index and reads the eight entries of the selected group one at a time over a read port that allows one request in flight. If no entry matches, it repeats the search in the group picked by the bitwise complement of the hash.

On a hit the walker reports the real address, the entry's offset inside the table and the two-bit protection field. It then updates the entry's status byte by byte: it sets the referenced flag if that flag is clear, and on a store it sets the changed flag if that flag is clear. A one-cycle `done` pulse ends every walk. The result outputs keep their values until the next walk starts. Whether the access is allowed is decided outside this block.

Top module: `hpt_walker`

## Requirements
- R1: A pulse on `seg_we` writes `seg_vsid` into segment register `seg_idx`. When a walk starts, the segment ID it uses is the one held by register `ea[31:28]`.
- R2: The group offset is `(hash << 6) & tbl_mask`, where `hash` is the 24-bit segment ID XOR `ea[27:12]`, zero-extended to 32 bits. Entry k of a group sits at `tbl_base + offset + 8k`. Its first word is at +0 and its second word at +4.
- R3: A first word matches when all of these hold: bit 31 (valid) is 1, bit 6 equals the pass number (0 for primary, 1 for secondary), bits 30:7 equal the segment ID, and bits 5:0 equal `ea[27:22]`.
- R4: Entries are read in order 0 to 7, and the first match wins. The second word of an entry is requested only after its first word has arrived, and only when that first word matches.
- R5: When all eight primary entries fail, the walker searches the group at `((~hash) << 6) & tbl_mask`. When all sixteen entries fail, it ends the walk with `hit`=0 and issues no write.
- R6: `rd_req_valid` stays high with `rd_addr` unchanged until `rd_req_ready` is seen. No new request is made while a response is outstanding.
- R7: On a hit, `raddr` = {second word[31:12], `ea[11:0]`}, `pte_off` = group offset + 8k, and `prot` = second word[1:0].
- R8: On a hit whose second word has bit 8 (referenced) clear, one byte write goes to entry address + 6 with data second word[15:8] | 0x01. Bytes are big-endian within each word.
- R9: On a store hit whose second word has bit 7 (changed) clear, one byte write goes to entry address + 7 with data second word[7:0] | 0x80. This write follows the referenced write when both are due. A load never writes the changed byte.
- R10: `done` is high for exactly one cycle, after the last write of the walk. `hit`, `raddr`, `pte_off` and `prot` hold until the next start. After reset, `done`, `hit`, `rd_req_valid` and `wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment register write strobe |
| seg_idx | input | 4 | Segment register index |
| seg_vsid | input | 24 | Segment ID to store |
| tbl_base | input | 32 | Table base address, 64-byte aligned |
| tbl_mask | input | 32 | Mask applied to the scaled hash |
| start | input | 1 | Starts a walk (taken when idle) |
| ea | input | 32 | Effective address, sampled at start |
| is_store | input | 1 | 1 for store access, 0 for load |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | 32 | Read word address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data word |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | 32 | Byte write address |
| wr_byte | output | 8 | Byte write data |
| done | output | 1 | Walk finished, one-cycle pulse |
| hit | output | 1 | Translation found |
| raddr | output | 32 | Real address |
| pte_off | output | 32 | Offset of the matched entry in the table |
| prot | output | 2 | Protection field of the matched entry |

## Verification
The checks rest on three assumptions about the inputs. `tbl_base` is 64-byte aligned, so every read address is word-aligned and every status write lands on byte 6 or 7 of an entry. A read response comes only when exactly one request is outstanding. `start` is raised only while the walker is idle. The bench's memory responder enforces the response rule itself: it grants a request only when nothing is pending, returns data after a random delay of 0 to 2 cycles, and stalls grants at random. The test sequence keeps the other two rules by fixing an aligned base and by waiting for `done` before each new start.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_SETR,
        ST_SETC,
        ST_FIN
    } walk_st_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int ADDR_W = 32,
    parameter int VSID_W = 24,
    parameter int PIDX_W = 16,
    parameter int GRP_SH = 6
) (
    input  logic [VSID_W-1:0] vsid,
    input  logic [PIDX_W-1:0] pidx,
    input  logic              second,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] grp_off
);
    logic [ADDR_W-1:0] hash;
    logic [ADDR_W-1:0] sel;

    always_comb begin
        hash    = ADDR_W'(vsid ^ VSID_W'(pidx));
        sel     = second ? ~hash : hash;
        grp_off = (sel << GRP_SH) & mask;
    end
endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
    parameter int VSID_W = 24,
    parameter int API_W  = 6
) (
    input  logic [VSID_W+API_W+1:0] word0,
    input  logic                    pass,
    input  logic [VSID_W-1:0]       vsid,
    input  logic [API_W-1:0]        api,
    output logic                    match
);
    localparam int V_BIT = VSID_W + API_W + 1;
    localparam int H_BIT = API_W;

    always_comb begin
        match = word0[V_BIT]
             && (word0[H_BIT] == pass)
             && (word0[V_BIT-1 -: VSID_W] == vsid)
             && (word0[API_W-1:0] == api);
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
    parameter int ADDR_W = 32,
    parameter int NSEG   = 16,
    parameter int NENT   = 8,
    parameter int VSID_W = 24,
    parameter int PG_SH  = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      seg_we,
    input  logic [$clog2(NSEG)-1:0]   seg_idx,
    input  logic [VSID_W-1:0]         seg_vsid,
    input  logic [ADDR_W-1:0]         tbl_base,
    input  logic [ADDR_W-1:0]         tbl_mask,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         ea,
    input  logic                      is_store,
    output logic                      rd_req_valid,
    input  logic                      rd_req_ready,
    output logic [ADDR_W-1:0]         rd_addr,
    input  logic                      rd_rsp_valid,
    input  logic [31:0]               rd_rsp_data,
    output logic                      wr_en,
    output logic [ADDR_W-1:0]         wr_addr,
    output logic [7:0]                wr_byte,
    output logic                      done,
    output logic                      hit,
    output logic [ADDR_W-1:0]         raddr,
    output logic [ADDR_W-1:0]         pte_off,
    output logic [1:0]                prot
);
    import hpt_pkg::*;

    localparam int SEG_W  = $clog2(NSEG);
    localparam int ENT_W  = $clog2(NENT);
    localparam int ENT_SH = 3;
    localparam int GRP_SH = ENT_SH + ENT_W;
    localparam int PIDX_W = ADDR_W - SEG_W - PG_SH;
    localparam int API_W  = 32 - VSID_W - 2;
    localparam int R_BIT  = 8;
    localparam int C_BIT  = 7;

    typedef struct packed {
        walk_st_e                      st;
        logic [NSEG-1:0][VSID_W-1:0]   segs;
        logic [ADDR_W-1:0]             ea;
        logic                          store;
        logic [VSID_W-1:0]             vsid;
        logic                          pass;
        logic [ENT_W-1:0]              idx;
        logic                          word;
        logic [31:0]                   w1;
        logic                          hit;
        logic [ADDR_W-1:0]             raddr;
        logic [ADDR_W-1:0]             off;
        logic [1:0]                    prot;
    } walk_t;

    walk_t q, n;
    logic [ADDR_W-1:0] grp_off;
    logic [ADDR_W-1:0] ent_off;
    logic              match;

    hpt_hash #(
        .ADDR_W(ADDR_W), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .GRP_SH(GRP_SH)
    ) u_hash (
        .vsid(q.vsid),
        .pidx(q.ea[PG_SH +: PIDX_W]),
        .second(q.pass),
        .mask(tbl_mask),
        .grp_off(grp_off)
    );

    hpt_match #(.VSID_W(VSID_W), .API_W(API_W)) u_match (
        .word0(rd_rsp_data),
        .pass(q.pass),
        .vsid(q.vsid),
        .api(q.ea[ADDR_W-SEG_W-1 -: API_W]),
        .match(match)
    );

    always_comb begin
        n            = q;
        ent_off      = grp_off + (ADDR_W'(q.idx) << ENT_SH);
        rd_req_valid = 1'b0;
        rd_addr      = tbl_base + ent_off + (ADDR_W'(q.word) << 2);
        wr_en        = 1'b0;
        wr_addr      = '0;
        wr_byte      = '0;

        if (seg_we) n.segs[seg_idx] = seg_vsid;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.ea    = ea;
                    n.store = is_store;
                    n.vsid  = q.segs[ea[ADDR_W-1 -: SEG_W]];
                    n.pass  = 1'b0;
                    n.idx   = '0;
                    n.word  = 1'b0;
                    n.st    = ST_REQ;
                end
            end
            ST_REQ: begin
                rd_req_valid = 1'b1;
                if (rd_req_ready) n.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rd_rsp_valid) begin
                    if (q.word) begin
                        n.w1    = rd_rsp_data;
                        n.hit   = 1'b1;
                        n.raddr = {rd_rsp_data[31:PG_SH], q.ea[PG_SH-1:0]};
                        n.off   = ent_off;
                        n.prot  = rd_rsp_data[1:0];
                        if (!rd_rsp_data[R_BIT])
                            n.st = ST_SETR;
                        else if (!rd_rsp_data[C_BIT] && q.store)
                            n.st = ST_SETC;
                        else
                            n.st = ST_FIN;
                    end else if (match) begin
                        n.word = 1'b1;
                        n.st   = ST_REQ;
                    end else if (q.idx != ENT_W'(NENT-1)) begin
                        n.idx = q.idx + 1'b1;
                        n.st  = ST_REQ;
                    end else if (!q.pass) begin
                        n.pass = 1'b1;
                        n.idx  = '0;
                        n.st   = ST_REQ;
                    end else begin
                        n.hit = 1'b0;
                        n.st  = ST_FIN;
                    end
                end
            end
            ST_SETR: begin
                wr_en   = 1'b1;
                wr_addr = tbl_base + ent_off + ADDR_W'(6);
                wr_byte = q.w1[15:8] | 8'h01;
                n.st    = (!q.w1[C_BIT] && q.store) ? ST_SETC : ST_FIN;
            end
            ST_SETC: begin
                wr_en   = 1'b1;
                wr_addr = tbl_base + ent_off + ADDR_W'(7);
                wr_byte = q.w1[7:0] | 8'h80;
                n.st    = ST_FIN;
            end
            ST_FIN: n.st = ST_IDLE;
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign done    = (q.st == ST_FIN);
    assign hit     = q.hit;
    assign raddr   = q.raddr;
    assign pte_off = q.off;
    assign prot    = q.prot;
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_rsp_valid,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_byte,
    input logic              done
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                            pend_q <= 1'b0;
        else if (rd_req_valid && rd_req_ready) pend_q <= 1'b1;
        else if (rd_rsp_valid)                 pend_q <= 1'b0;
    end

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr));

    a_r6_single_out: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !rd_req_valid);

    a_r2_word_align: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> rd_addr[1:0] == 2'b00);

    a_r8_status_lane: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_addr[2:1] == 2'b11);

    a_r8_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr[2:0] == 3'd6 |-> wr_byte[0]);

    a_r9_chg_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr[2:0] == 3'd7 |-> wr_byte[7]);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req_valid && !wr_en && !pend_q);
endmodule

bind hpt_walker hpt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid),
    .wr_en(wr_en),
    .wr_addr(wr_addr),
    .wr_byte(wr_byte),
    .done(done)
);

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
    localparam logic [31:0] BASE = 32'h0000_2000;
    localparam logic [31:0] MASK = 32'h0000_0FC0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_we = 1'b0;
    logic [3:0]  seg_idx = '0;
    logic [23:0] seg_vsid = '0;
    logic        start = 1'b0;
    logic [31:0] ea = '0;
    logic        is_store = 1'b0;
    logic        rd_req_valid, rd_req_ready = 1'b0;
    logic [31:0] rd_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        wr_en;
    logic [31:0] wr_addr;
    logic [7:0]  wr_byte;
    logic        done, hit;
    logic [31:0] raddr, pte_off;
    logic [1:0]  prot;

    always #5 clk = ~clk;

    hpt_walker uut (
        .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_idx(seg_idx),
        .seg_vsid(seg_vsid), .tbl_base(BASE), .tbl_mask(MASK),
        .start(start), .ea(ea), .is_store(is_store),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_byte(wr_byte), .done(done), .hit(hit), .raddr(raddr),
        .pte_off(pte_off), .prot(prot)
    );

    logic [31:0] mem [4096];
    logic [23:0] segs [16];
    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, wr_cnt = 0, hold_err = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder: one request in flight, random stall and latency.
    initial begin
        logic        pend = 1'b0;
        int          lat = 0;
        logic [31:0] a = '0;
        logic        was_stalled = 1'b0;
        logic [31:0] stall_addr = '0;
        forever begin
            @(negedge clk);
            if (wr_en) begin
                mem[wr_addr[13:2]][8*(3-wr_addr[1:0]) +: 8] = wr_byte;
                wr_cnt++;
            end
            if (was_stalled && (!rd_req_valid || rd_addr !== stall_addr)) hold_err++;
            was_stalled  = 1'b0;
            rd_rsp_valid = 1'b0;
            if (pend) begin
                rd_req_ready = 1'b0;
                if (lat == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = mem[a[13:2]];
                    pend = 1'b0;
                end else lat--;
            end else if (rd_req_valid) begin
                rd_req_ready = ($urandom % 4) != 0;
                if (rd_req_ready) begin
                    pend = 1'b1;
                    a    = rd_addr;
                    lat  = $urandom % 3;
                    rd_cnt++;
                end else begin
                    was_stalled = 1'b1;
                    stall_addr  = rd_addr;
                end
            end else rd_req_ready = 1'b0;
        end
    end

    function automatic logic [31:0] grp(input logic [31:0] e, input logic p);
        logic [31:0] h;
        h = {8'd0, segs[e[31:28]] ^ {8'd0, e[27:12]}};
        return ((p ? ~h : h) << 6) & MASK;
    endfunction

    task automatic seg_write(input logic [3:0] i, input logic [23:0] v);
        @(negedge clk);
        seg_we = 1'b1; seg_idx = i; seg_vsid = v; segs[i] = v;
        @(negedge clk);
        seg_we = 1'b0;
    endtask

    task automatic fill(input logic [31:0] e, input bit junk);
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 16; k++)
                mem[(BASE + grp(e, p[0]) + 4*k) >> 2] = junk ? $urandom : 32'd0;
    endtask

    task automatic plant(input logic [31:0] e, input logic p, input int k, input logic [31:0] w1);
        logic [31:0] a;
        a = BASE + grp(e, p) + 8*k;
        mem[a >> 2]       = {1'b1, segs[e[31:28]], p, e[27:22]};
        mem[(a + 4) >> 2] = w1;
    endtask

    task automatic walk(input logic [31:0] e, input logic st);
        logic        ehit = 1'b0;
        logic [31:0] er = '0, eo = '0, ew1 = '0, a = '0, w0;
        logic [1:0]  ep = '0;
        int          nrd = 0, nwr = 0, guard;
        bit          found = 0;
        logic [23:0] v;
        v = segs[e[31:28]];
        for (int p = 0; p < 2 && !found; p++)
            for (int k = 0; k < 8 && !found; k++) begin
                a  = BASE + grp(e, p[0]) + 8*k;
                w0 = mem[a >> 2];
                nrd++;
                if (w0[31] && w0[6] == p[0] && w0[30:7] == v && w0[5:0] == e[27:22]) begin
                    found = 1; nrd++;
                    ew1  = mem[(a + 4) >> 2];
                    ehit = 1'b1;
                    er   = {ew1[31:12], e[11:0]};
                    eo   = a - BASE;
                    ep   = ew1[1:0];
                    if (!ew1[8]) begin nwr++; ew1[8] = 1'b1; end
                    if (!ew1[7] && st) begin nwr++; ew1[7] = 1'b1; end
                end
            end
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        start = 1'b1; ea = e; is_store = st;
        @(negedge clk);
        start = 1'b0; ea = $urandom;
        guard = 0;
        while (!done && guard < 1000) begin @(negedge clk); guard++; end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R10 watchdog actual=no-done expected=done");
            return;
        end
        check("R1 R3 R5 hit", 32'(hit), 32'(ehit));
        check("R4 R5 read count", rd_cnt, nrd);
        if (ehit) begin
            check("R7 raddr", raddr, er);
            check("R2 R7 pte_off", pte_off, eo);
            check("R7 prot", 32'(prot), 32'(ep));
            check("R8 R9 second word after update", mem[(BASE + eo + 4) >> 2], ew1);
        end
        check("R8 R9 write count", wr_cnt, nwr);
        @(negedge clk);
        check("R10 done one cycle", 32'(done), 0);
        check("R10 hit held", 32'(hit), 32'(ehit));
    endtask

    initial begin
        logic [31:0] e;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) segs[i] = '0;
        repeat (3) @(negedge clk);
        check("R10 reset done", 32'(done), 0);
        check("R10 reset hit", 32'(hit), 0);
        check("R10 reset rd_req_valid", 32'(rd_req_valid), 0);
        check("R10 reset wr_en", 32'(wr_en), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) seg_write(i[3:0], 24'($urandom));

        // Primary slot 0, both flags clear, store: two writes (R8, R9)
        e = 32'h3456_7ABC; fill(e, 0);
        plant(e, 1'b0, 0, 32'hABCDE002);
        walk(e, 1'b1);
        // Secondary slot 7, load, both clear: referenced only (R5, R9)
        e = 32'h9001_2345; fill(e, 0);
        plant(e, 1'b1, 7, 32'h12345001);
        walk(e, 1'b0);
        // Full miss after 16 entries (R5)
        e = 32'h5FFF_F000; fill(e, 0);
        walk(e, 1'b1);
        // Flags already set: no writes (R8, R9)
        e = 32'h7777_7777; fill(e, 0);
        plant(e, 1'b0, 3, 32'hFEDCB183);
        walk(e, 1'b1);
        // Referenced set, changed clear, store: changed byte only (R9)
        e = 32'hA0A0_5555; fill(e, 0);
        plant(e, 1'b0, 5, 32'h0F0F0101);
        walk(e, 1'b1);
        // Decoys: wrong pass bit and invalid entries ahead of the real one (R3)
        e = 32'hC123_4567; fill(e, 0);
        plant(e, 1'b0, 1, 32'h11111103);
        mem[(BASE + grp(e, 1'b0) + 8) >> 2][6] = 1'b1;
        plant(e, 1'b0, 2, 32'h22222103);
        mem[(BASE + grp(e, 1'b0) + 16) >> 2][31] = 1'b0;
        plant(e, 1'b1, 0, 32'h33333000);
        walk(e, 1'b0);
        // New segment ID steers the walk (R1)
        seg_write(4'd5, 24'hABCDEF);
        e = 32'h5123_4000; fill(e, 0);
        plant(e, 1'b0, 4, 32'h44444102);
        walk(e, 1'b0);
        // Two matches: lower slot wins (R4)
        e = 32'h2468_ACE0; fill(e, 0);
        plant(e, 1'b0, 6, 32'h66666100);
        plant(e, 1'b0, 2, 32'h55555100);
        walk(e, 1'b0);

        for (int t = 0; t < 60; t++) begin
            int m;
            e = $urandom;
            if (t % 10 == 9) seg_write(4'($urandom), 24'($urandom));
            fill(e, 1);
            m = $urandom % 10;
            if (m < 6)      plant(e, 1'b0, $urandom % 8, $urandom);
            else if (m < 9) plant(e, 1'b1, $urandom % 8, $urandom);
            walk(e, 1'($urandom));
        end

        check("R6 request held while stalled", hold_err, 0);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule